// File: doc/BRIEF.md
# Repeated String Transfer Sequencer

This block runs the repeated element-transfer instructions of a processor core in hardware. One start pulse hands it an operation class (move memory to memory, store the accumulator, load into the accumulator, read a port into memory, write memory to a port), an element size of one, two or four bytes, a direction flag, a repeat flag, an addressing-size select, a paging flag, the count register, the source and destination pointers and the accumulator. It then issues one element access per clock on a memory interface with combinational read data and a port interface. It returns the updated pointers, count and accumulator, the number of elements it performed (for the timestamp counter) and a restart flag.

A repeated operation is cut into bounded chunks. A chunk stops when the count runs out, when it has done the iteration cap plus one element, or, with paging on, when the next element would begin on another 4 KiB page. If count remains, the restart flag tells the core to run the same instruction again from the state the block has reached. Address translation and faults are handled elsewhere.

Top module: `rep_xfer_seq`

## Requirements
- R1: The pointer step is the element size in bytes (sizeSel 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). It is added when dirDown is 0 and subtracted when dirDown is 1. After a chunk of n elements each pointer in use has moved by n steps.
- R2: With repeatOn = 1 and a zero effective count, done rises in the second cycle after start. No memory or port access is made, restart is 0, iterOut is 0 and every pointer, the count and the accumulator are unchanged.
- R3: With repeatOn = 0, exactly one element is transferred, the pointers in use step once, the count is returned unchanged and restart is 0.
- R4: With paging off, a repeated chunk performs min(count, CAP_EXTRA + 1) elements (CAP_EXTRA defaults to 4096).
- R5: With paging on, the extra elements allowed beyond the first are the page offset of the pointer shifted right by log2(size) when moving down. When moving up they are (4095 minus the page offset) shifted the same way. A move takes the smaller value of its two pointers. The cap of R4 still applies.
- R6: restart is 1 with done exactly when repeatOn = 1 and the remaining effective count is nonzero.
- R7: iterOut equals the number of elements performed in the chunk, and countOut holds the effective count minus that number.
- R8: Operation codes: opSel 0 move, 1 store, 2 load, 3 port input, 4 port output. Store and port input use only the destination pointer. Load and port output use only the source pointer. A pointer that is not used comes back unchanged.
- R9: With wideAddr = 0, only bits 15:0 of the pointers and of the count take part and change, with 16-bit wraparound. Bits 31:16 are returned unchanged. With wideAddr = 1, all 32 bits are used.
- R10: done is a single-cycle pulse. Element k of a chunk is accessed in cycle k after the start edge, and done rises in the cycle after the last element.
- R11: Data travels in the low bits of the 32-bit data buses. A move writes the data read. A store writes the low element of the accumulator. A load replaces only the low element of the accumulator. A port input writes portRdData. A port output sends the data read.
- R12: After reset, done, restart and every access enable are 0. A start pulse while a chunk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a chunk with the operands below |
| opSel | input | 3 | Operation class (R8 encoding) |
| sizeSel | input | 2 | Element size: 0 byte, 1 word, 2 doubleword |
| dirDown | input | 1 | 1 = pointers step downward |
| repeatOn | input | 1 | Repeat prefix present |
| wideAddr | input | 1 | 1 = 32-bit addressing, 0 = 16-bit |
| pagingOn | input | 1 | Limit chunks to the current 4 KiB page |
| countIn | input | 32 | Count register |
| srcIn | input | 32 | Source pointer |
| dstIn | input | 32 | Destination pointer |
| accIn | input | 32 | Accumulator |
| memRdEn | output | 1 | Memory read this cycle |
| memRdAddr | output | 32 | Read byte address |
| memRdData | input | 32 | Read data, same cycle |
| memWrEn | output | 1 | Memory write at the next edge |
| memWrAddr | output | 32 | Write byte address |
| memWrData | output | 32 | Write data, low element bits |
| memSize | output | 2 | Element size of the current access |
| portRdEn | output | 1 | Port read this cycle |
| portRdData | input | 32 | Port read data, same cycle |
| portWrEn | output | 1 | Port write at the next edge |
| portWrData | output | 32 | Port write data |
| done | output | 1 | Chunk finished (one cycle) |
| restart | output | 1 | Re-execute the instruction |
| srcOut | output | 32 | Updated source pointer |
| dstOut | output | 32 | Updated destination pointer |
| countOut | output | 32 | Updated count |
| accOut | output | 32 | Updated accumulator |
| iterOut | output | 13 | Elements performed in this chunk |

## Verification
The bench targets the chunk boundaries. It runs a store that begins 16 bytes below a page edge, a downward word load that starts near offset zero, a move whose destination room is zero while its source room is large, and an unpaged run longer than the cap. A design that got the room formula, the min of the two pointers or the cap off by one would return a wrong count, pointer or iteration number, or a wrong restart flag. It also covers a zero count under repeat, which must make no access at all, and a 16-bit pointer that wraps past 0xFFFF, where a design that carried into the upper half would show up in dstOut. A second start during a long chunk would show up as an unexpected extra done.

// File: rtl/rep_xfer_pkg.sv
`timescale 1ns/1ps
package rep_xfer_pkg;

  typedef enum logic [2:0] {
    OP_MOVE  = 3'd0,
    OP_STORE = 3'd1,
    OP_LOAD  = 3'd2,
    OP_IN    = 3'd3,
    OP_OUT   = 3'd4
  } opKind_e;

  typedef struct packed {
    logic capture;   // latch operands
    logic stepElem;  // perform one element
    logic finish;    // chunk complete
  } ctrlStrobe_t;

  function automatic logic [1:0] sizeShift(input logic [1:0] sz);
    case (sz)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [31:0] elemMask(input logic [1:0] sh);
    case (sh)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic readsSrc(input opKind_e op);
    return (op == OP_MOVE) || (op == OP_LOAD) || (op == OP_OUT);
  endfunction

  function automatic logic writesDst(input opKind_e op);
    return (op == OP_MOVE) || (op == OP_STORE) || (op == OP_IN);
  endfunction

endpackage

// File: rtl/rep_xfer_ctrl.sv
`timescale 1ns/1ps
module rep_xfer_ctrl
  import rep_xfer_pkg::*;
#(
  parameter int LIM_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             skipNow,
  input  logic [LIM_W-1:0] chunkBudget,
  input  logic             cntOne,
  output ctrlStrobe_t      strobe
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} seqState_e;

  seqState_e        state;
  logic [LIM_W-1:0] budget;
  logic             lastElem;

  assign lastElem = (budget == LIM_W'(1)) || cntOne;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      budget <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          budget <= chunkBudget;
          state  <= skipNow ? S_FIN : S_RUN;
        end
        S_RUN: begin
          budget <= budget - LIM_W'(1);
          if (lastElem) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.capture  = (state == S_IDLE) && start;
    strobe.stepElem = (state == S_RUN);
    strobe.finish   = (state == S_FIN);
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> !strobe.finish);

  // R12
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && start && !lastElem) |=> (state == S_RUN));

endmodule

// File: rtl/rep_xfer_dp.sv
`timescale 1ns/1ps
module rep_xfer_dp
  import rep_xfer_pkg::*;
#(
  parameter int CAP_EXTRA = 4096,
  parameter int PAGE_BITS = 12,
  parameter int LIM_W     = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [2:0]       opIn,
  input  logic [1:0]       sizeIn,
  input  logic             dirIn,
  input  logic             repIn,
  input  logic             wideIn,
  input  logic             pagingIn,
  input  logic [31:0]      countIn,
  input  logic [31:0]      srcIn,
  input  logic [31:0]      dstIn,
  input  logic [31:0]      accIn,
  input  logic [31:0]      memRdData,
  input  logic [31:0]      portRdData,
  output logic             skipNow,
  output logic [LIM_W-1:0] chunkBudget,
  output logic             cntOne,
  output logic             memRdEn,
  output logic [31:0]      memRdAddr,
  output logic             memWrEn,
  output logic [31:0]      memWrAddr,
  output logic [31:0]      memWrData,
  output logic [1:0]       memSize,
  output logic             portRdEn,
  output logic             portWrEn,
  output logic [31:0]      portWrData,
  output logic             restart,
  output logic [31:0]      srcOut,
  output logic [31:0]      dstOut,
  output logic [31:0]      countOut,
  output logic [31:0]      accOut,
  output logic [LIM_W-1:0] iterOut
);

  // operand registers
  opKind_e          opReg;
  logic [1:0]       shReg;
  logic             dirReg, repReg, wideReg;
  logic [31:0]      srcPtr, dstPtr, cntReg, accReg;
  logic [LIM_W-1:0] iterCnt;

  // ---------------- chunk budget from the start operands ----------------
  function automatic int unsigned pageRoom(input logic [31:0] a, input logic dn,
                                           input logic [1:0] sh);
    logic [PAGE_BITS-1:0] off;
    off = dn ? a[PAGE_BITS-1:0] : ~a[PAGE_BITS-1:0];
    return 32'(off) >> sh;
  endfunction

  opKind_e     opNow;
  logic [1:0]  shNow;
  logic [31:0] cntInEff;
  int unsigned srcRoom, dstRoom, extraAllowed;

  always_comb begin
    opNow        = opKind_e'(opIn);
    shNow        = sizeShift(sizeIn);
    cntInEff     = wideIn ? countIn : {16'h0, countIn[15:0]};
    srcRoom      = pageRoom(srcIn, dirIn, shNow);
    dstRoom      = pageRoom(dstIn, dirIn, shNow);
    extraAllowed = CAP_EXTRA;
    if (pagingIn) begin
      if (readsSrc(opNow) && srcRoom < extraAllowed)  extraAllowed = srcRoom;
      if (writesDst(opNow) && dstRoom < extraAllowed) extraAllowed = dstRoom;
    end
    chunkBudget = repIn ? LIM_W'(extraAllowed + 1) : LIM_W'(1);
    skipNow     = repIn && (cntInEff == 32'h0);
  end

  // ---------------- per-element arithmetic ----------------
  logic [31:0] stepVal, elemMaskNow, cntEff;

  function automatic logic [31:0] advance(input logic [31:0] p, input logic [31:0] d,
                                          input logic wide);
    return wide ? (p + d) : {p[31:16], p[15:0] + d[15:0]};
  endfunction

  always_comb begin
    elemMaskNow = elemMask(shReg);
    stepVal     = dirReg ? (32'h0 - (32'h1 << shReg)) : (32'h1 << shReg);
    cntEff      = wideReg ? cntReg : {16'h0, cntReg[15:0]};
    cntOne      = repReg && (cntEff == 32'h1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg   <= OP_MOVE;
      shReg   <= '0;
      dirReg  <= 1'b0;
      repReg  <= 1'b0;
      wideReg <= 1'b0;
      srcPtr  <= '0;
      dstPtr  <= '0;
      cntReg  <= '0;
      accReg  <= '0;
      iterCnt <= '0;
    end else if (strobe.capture) begin
      opReg   <= opNow;
      shReg   <= shNow;
      dirReg  <= dirIn;
      repReg  <= repIn;
      wideReg <= wideIn;
      srcPtr  <= srcIn;
      dstPtr  <= dstIn;
      cntReg  <= countIn;
      accReg  <= accIn;
      iterCnt <= '0;
    end else if (strobe.stepElem) begin
      if (readsSrc(opReg))  srcPtr <= advance(srcPtr, stepVal, wideReg);
      if (writesDst(opReg)) dstPtr <= advance(dstPtr, stepVal, wideReg);
      if (repReg)           cntReg <= advance(cntReg, 32'hFFFF_FFFF, wideReg);
      if (opReg == OP_LOAD)
        accReg <= (accReg & ~elemMaskNow) | (memRdData & elemMaskNow);
      iterCnt <= iterCnt + LIM_W'(1);
    end
  end

  // ---------------- access interface ----------------
  always_comb begin
    memRdEn   = strobe.stepElem && readsSrc(opReg);
    memWrEn   = strobe.stepElem && writesDst(opReg);
    portRdEn  = strobe.stepElem && (opReg == OP_IN);
    portWrEn  = strobe.stepElem && (opReg == OP_OUT);
    memRdAddr = srcPtr;
    memWrAddr = dstPtr;
    memSize   = shReg;
    case (opReg)
      OP_MOVE:  memWrData = memRdData & elemMaskNow;
      OP_STORE: memWrData = accReg & elemMaskNow;
      OP_IN:    memWrData = portRdData & elemMaskNow;
      default:  memWrData = 32'h0;
    endcase
    portWrData = memRdData & elemMaskNow;
  end

  assign restart  = strobe.finish && repReg && (cntEff != 32'h0);
  assign srcOut   = srcPtr;
  assign dstOut   = dstPtr;
  assign countOut = cntReg;
  assign accOut   = accReg;
  assign iterOut  = iterCnt;

  // R3
  norep_count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepElem && !repReg) |=> $stable(cntReg));

  // R8
  src_unused_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepElem && (opReg == OP_STORE || opReg == OP_IN)) |=> $stable(srcPtr));

  // R8
  dst_unused_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepElem && (opReg == OP_LOAD || opReg == OP_OUT)) |=> $stable(dstPtr));

  // R9
  narrow_upper_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepElem && !wideReg) |=>
      ($stable(srcPtr[31:16]) && $stable(dstPtr[31:16]) && $stable(cntReg[31:16])));

  // R4
  iter_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    iterCnt <= LIM_W'(CAP_EXTRA + 1));

endmodule

// File: rtl/rep_xfer_seq.sv
`timescale 1ns/1ps
module rep_xfer_seq
  import rep_xfer_pkg::*;
#(
  parameter int CAP_EXTRA = 4096,
  parameter int PAGE_BITS = 12,
  localparam int LIM_W    = $clog2(CAP_EXTRA + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [2:0]       opSel,
  input  logic [1:0]       sizeSel,
  input  logic             dirDown,
  input  logic             repeatOn,
  input  logic             wideAddr,
  input  logic             pagingOn,
  input  logic [31:0]      countIn,
  input  logic [31:0]      srcIn,
  input  logic [31:0]      dstIn,
  input  logic [31:0]      accIn,
  output logic             memRdEn,
  output logic [31:0]      memRdAddr,
  input  logic [31:0]      memRdData,
  output logic             memWrEn,
  output logic [31:0]      memWrAddr,
  output logic [31:0]      memWrData,
  output logic [1:0]       memSize,
  output logic             portRdEn,
  input  logic [31:0]      portRdData,
  output logic             portWrEn,
  output logic [31:0]      portWrData,
  output logic             done,
  output logic             restart,
  output logic [31:0]      srcOut,
  output logic [31:0]      dstOut,
  output logic [31:0]      countOut,
  output logic [31:0]      accOut,
  output logic [LIM_W-1:0] iterOut
);

  ctrlStrobe_t      strobe;
  logic             skipNow, cntOne;
  logic [LIM_W-1:0] chunkBudget;

  rep_xfer_ctrl #(.LIM_W(LIM_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .skipNow     (skipNow),
    .chunkBudget (chunkBudget),
    .cntOne      (cntOne),
    .strobe      (strobe)
  );

  rep_xfer_dp #(.CAP_EXTRA(CAP_EXTRA), .PAGE_BITS(PAGE_BITS), .LIM_W(LIM_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .opIn        (opSel),
    .sizeIn      (sizeSel),
    .dirIn       (dirDown),
    .repIn       (repeatOn),
    .wideIn      (wideAddr),
    .pagingIn    (pagingOn),
    .countIn     (countIn),
    .srcIn       (srcIn),
    .dstIn       (dstIn),
    .accIn       (accIn),
    .memRdData   (memRdData),
    .portRdData  (portRdData),
    .skipNow     (skipNow),
    .chunkBudget (chunkBudget),
    .cntOne      (cntOne),
    .memRdEn     (memRdEn),
    .memRdAddr   (memRdAddr),
    .memWrEn     (memWrEn),
    .memWrAddr   (memWrAddr),
    .memWrData   (memWrData),
    .memSize     (memSize),
    .portRdEn    (portRdEn),
    .portWrEn    (portWrEn),
    .portWrData  (portWrData),
    .restart     (restart),
    .srcOut      (srcOut),
    .dstOut      (dstOut),
    .countOut    (countOut),
    .accOut      (accOut),
    .iterOut     (iterOut)
  );

  assign done = strobe.finish;

  // R6
  restart_needs_rest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && restart) |-> (countOut != 32'h0));

endmodule

// File: tb/rep_xfer_seq_tb.sv
`timescale 1ns/1ps
module rep_xfer_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opSel = '0;
  logic [1:0]  sizeSel = '0;
  logic        dirDown = 1'b0, repeatOn = 1'b0, wideAddr = 1'b1, pagingOn = 1'b0;
  logic [31:0] countIn = '0, srcIn = '0, dstIn = '0, accIn = '0;
  logic        memRdEn, memWrEn, portRdEn, portWrEn, done, restart;
  logic [31:0] memRdAddr, memRdData, memWrAddr, memWrData, portRdData, portWrData;
  logic [31:0] srcOut, dstOut, countOut, accOut;
  logic [1:0]  memSize;
  logic [12:0] iterOut;

  always #2.5 clk = ~clk;

  rep_xfer_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .sizeSel(sizeSel),
    .dirDown(dirDown), .repeatOn(repeatOn), .wideAddr(wideAddr), .pagingOn(pagingOn),
    .countIn(countIn), .srcIn(srcIn), .dstIn(dstIn), .accIn(accIn),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData), .memSize(memSize),
    .portRdEn(portRdEn), .portRdData(portRdData), .portWrEn(portWrEn),
    .portWrData(portWrData), .done(done), .restart(restart), .srcOut(srcOut),
    .dstOut(dstOut), .countOut(countOut), .accOut(accOut), .iterOut(iterOut)
  );

  // ---------------- memory and port models ----------------
  logic [7:0]  mem [0:4095];
  logic [31:0] portVal = 32'h0000_A000;
  logic [31:0] portLog [$];

  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {mem[12'(a + 3)], mem[12'(a + 2)], mem[12'(a + 1)], mem[12'(a)]};
  endfunction

  assign memRdData  = rd32(memRdAddr);
  assign portRdData = portVal;

  always @(posedge clk) begin
    if (memWrEn)
      for (int i = 0; i < (1 << ((memSize == 2'd0) ? 0 : (memSize == 2'd1) ? 1 : 2)); i++)
        mem[12'(memWrAddr + 32'(i))] <= memWrData[8*i +: 8];
    if (portRdEn) portVal <= portVal + 32'h1;
    if (portWrEn) portLog.push_back(portWrData);
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    string       tag;
    logic [31:0] src, dst, cnt, acc;
    int          iter, accesses;
    logic        rst;
  } expItem_t;

  expItem_t expQ [$];
  int checks = 0, errors = 0, doneCnt = 0, accTotal = 0;

  task automatic check32(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && (memRdEn || memWrEn || portRdEn || portWrEn)) accTotal++;
    if (rstN && done) begin
      doneCnt++;
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12 unexpected done actual=1 expected=0");
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check32(e.tag, "srcOut", srcOut, e.src);
        check32(e.tag, "dstOut", dstOut, e.dst);
        check32(e.tag, "countOut", countOut, e.cnt);
        check32(e.tag, "accOut", accOut, e.acc);
        check32(e.tag, "iterOut", 32'(iterOut), 32'(e.iter));
        check32(e.tag, "restart", 32'(restart), 32'(e.rst));
        check32(e.tag, "accesses", 32'(accTotal), 32'(e.accesses));
      end
    end
  end

  // ---------------- driver with requirement model ----------------
  function automatic int roomOf(input logic [31:0] a, input logic dn, input int sh);
    int off;
    off = dn ? int'(a[11:0]) : 4095 - int'(a[11:0]);
    return off >> sh;
  endfunction

  function automatic logic [31:0] moveBy(input logic [31:0] p, input logic [31:0] d,
                                         input logic wide);
    logic [31:0] r;
    r = p + d;
    return wide ? r : {p[31:16], r[15:0]};
  endfunction

  task automatic runOp(input string tag, input logic [2:0] op, input logic [1:0] sz,
                       input logic dn, input logic rep, input logic wide, input logic pg,
                       input logic [31:0] cnt, input logic [31:0] src,
                       input logic [31:0] dst, input logic [31:0] acc,
                       input logic [31:0] expAcc, input bit busyPoke);
    expItem_t e;
    int sh, n, extra;
    logic usesS, usesD;
    logic [31:0] cntEff, delta;
    int prevDone;
    sh     = (sz == 2'd0) ? 0 : (sz == 2'd1) ? 1 : 2;
    usesS  = (op == 3'd0) || (op == 3'd2) || (op == 3'd4);
    usesD  = (op == 3'd0) || (op == 3'd1) || (op == 3'd3);
    cntEff = wide ? cnt : {16'h0, cnt[15:0]};
    if (!rep) n = 1;
    else if (cntEff == 0) n = 0;
    else begin
      extra = 4096;
      if (pg && usesS && roomOf(src, dn, sh) < extra) extra = roomOf(src, dn, sh);
      if (pg && usesD && roomOf(dst, dn, sh) < extra) extra = roomOf(dst, dn, sh);
      n = (cntEff < 32'(extra + 1)) ? int'(cntEff) : extra + 1;
    end
    delta = 32'(n) << sh;
    if (dn) delta = 32'h0 - delta;
    e.tag      = tag;
    e.src      = usesS ? moveBy(src, delta, wide) : src;
    e.dst      = usesD ? moveBy(dst, delta, wide) : dst;
    e.cnt      = rep ? moveBy(cnt, 32'h0 - 32'(n), wide) : cnt;
    e.acc      = expAcc;
    e.iter     = n;
    e.rst      = rep && ((cntEff - 32'(n)) != 0);
    e.accesses = accTotal + n;
    expQ.push_back(e);
    prevDone = doneCnt;
    @(negedge clk);
    opSel = op; sizeSel = sz; dirDown = dn; repeatOn = rep; wideAddr = wide;
    pagingOn = pg; countIn = cnt; srcIn = src; dstIn = dst; accIn = acc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (busyPoke) begin
      repeat (10) @(negedge clk);
      opSel = 3'd1; countIn = 32'd3; dstIn = 32'h800;
      start = 1'b1;                  // R12: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (doneCnt == prevDone) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R12: reset state
    check32("R12", "done", 32'(done), 0);
    check32("R12", "restart", 32'(restart), 0);
    check32("R12", "enables", 32'({memRdEn, memWrEn, portRdEn, portWrEn}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R7 R11: byte move upward, repeat, count 4
    runOp("R1_move_up", 3'd0, 2'd0, 0, 1, 1, 0, 32'd4, 32'h100, 32'h200, 32'h0, 32'h0, 0);
    check32("R11", "move copy", rd32(32'h200), rd32(32'h100));

    // R1: doubleword move downward, count 3
    runOp("R1_move_down", 3'd0, 2'd2, 1, 1, 1, 0, 32'd3, 32'h310, 32'h410, 32'h0, 32'h0, 0);
    check32("R1", "move down copy", rd32(32'h408), rd32(32'h308));

    // R2: repeat with zero count, no access
    runOp("R2_zero", 3'd0, 2'd1, 0, 1, 1, 0, 32'd0, 32'h120, 32'h220, 32'h55, 32'h55, 0);

    // R3 R11: single word store, count untouched
    mem[12'h502] = 8'h00;
    runOp("R3_single", 3'd1, 2'd1, 0, 0, 1, 0, 32'd7, 32'h0, 32'h500, 32'hDEADBEEF,
          32'hDEADBEEF, 0);
    check32("R11", "store word", 32'({mem[12'h501], mem[12'h500]}), 32'hBEEF);
    check32("R3", "next byte untouched", 32'(mem[12'h502]), 32'h00);

    // R5 R6: paged byte store 16 bytes under a page edge
    runOp("R5_store_edge", 3'd1, 2'd0, 0, 1, 1, 1, 32'd100, 32'h0, 32'h0FF0, 32'h5A,
          32'h5A, 0);
    check32("R11", "store byte", 32'(mem[12'hFFF]), 32'h5A);

    // R5 R9 R11: paged word load downward, 16-bit addressing
    mem[0] = 8'h34; mem[1] = 8'h12;
    runOp("R9_load_down", 3'd2, 2'd1, 1, 1, 0, 1, 32'h1234_0032, 32'hABCD_0006,
          32'h0000_9999, 32'h7777_8888, 32'h7777_1234, 0);

    // R5: move limited by the destination pointer
    runOp("R5_move_min", 3'd0, 2'd2, 0, 1, 1, 1, 32'd10, 32'h100, 32'h0FFC, 32'h0, 32'h0, 0);

    // R11: port input words
    begin
      logic [31:0] pv;
      pv = portVal;
      runOp("R11_in", 3'd3, 2'd1, 0, 1, 1, 0, 32'd3, 32'h0, 32'h600, 32'h0, 32'h0, 0);
      check32("R11", "port in word", 32'({mem[12'h603], mem[12'h602]}), (pv + 1) & 32'hFFFF);
    end

    // R11: port output doublewords
    portLog.delete();
    runOp("R11_out", 3'd4, 2'd2, 0, 1, 1, 0, 32'd2, 32'h700, 32'h0, 32'h0, 32'h0, 0);
    check32("R11", "port log size", 32'(portLog.size()), 32'd2);
    if (portLog.size() == 2) check32("R11", "port out data", portLog[1], rd32(32'h704));

    // R9 R6: 16-bit wrap with upper count bits set
    runOp("R9_wrap", 3'd1, 2'd0, 0, 1, 0, 0, 32'h0001_0002, 32'h0, 32'h1234_FFFF, 32'h1,
          32'h1, 0);

    // R4 R12: cap on an unpaged run, second start ignored
    runOp("R4_cap", 3'd1, 2'd0, 0, 1, 1, 0, 32'd5000, 32'h0, 32'h0, 32'hC3, 32'hC3, 1);
    repeat (10) @(negedge clk);
    check32("R12", "done count", 32'(doneCnt), 32'd11);
    check32("R10", "queue drained", 32'(expQ.size()), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule